// File: doc/BRIEF.md
# Board Interrupt Aggregator with Register Bank

This block sits in a board-level programmable device between sixteen external interrupt sources and a single interrupt request line into the host processor. Each source passes through a two-stage synchronizer and a registered change detector. An enable mask selects which sources may reach the host. When an enabled source changes level, the status register is replaced by a one-hot code naming that source, and the host line takes the source's new level. A change on a masked source only updates the block's record of the source levels.

The host reaches the block over a plain synchronous register bus with an address, write data, write enable, read enable and registered read data. Besides the enable mask and the status register, the bank holds ten general 32-bit storage registers for LEDs, switches, miscellaneous control and card-slot control. A write to the enable mask also produces a sixteen-bit per-source drive vector. This vector is the recorded levels XOR the low status bits, and it becomes the new level record.

Top module: `board_irq_hub`

## Requirements
- R1: After reset, every register reads zero, and `irq_host`, `pin_drive` and `bus_rdata` are zero.
- R2: The ten general registers at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4 store all 32 written bits and read them back unchanged.
- R3: Writes to the enable mask (offset 0xC0) and to the status register (offset 0xD0) keep only the bits set in 0x000FEEFF. Every other bit reads back as zero.
- R4: A source i whose enable bit i is 1 changes level. After the fourth rising clock edge following that change, the status register reads exactly 1<<i and `irq_host` equals the new level of source i.
- R5: A change on a source whose enable bit is 0 leaves the status register and `irq_host` unchanged.
- R6: When several enabled sources are handled in the same cycle, the lowest-numbered one sets the status code and the level on `irq_host`.
- R7: When an enabled source change is handled in the same cycle as a bus write to the status register, the bus write is discarded and the one-hot code is stored.
- R8: A write to the enable mask sets `pin_drive` to the recorded levels XOR status bits 15:0 and stores that value as the new level record. The record tracks every source change, enabled or not, and `pin_drive` changes only on such writes.
- R9: Reads at any offset not listed in R2 or R3 return zero. Writes to those offsets change no register.
- R10: `bus_rdata` is loaded on the clock edge at which `bus_rd` is high and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; read data is valid after the next rising edge |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | 16 | Asynchronous external interrupt source levels |
| irq_host | output | 1 | Interrupt line to the host |
| pin_drive | output | 16 | Per-source drive vector produced by enable-mask writes |

## Verification
The embedded properties are checked on every cycle. They cover the following: a handled enabled change leaves a single status bit set, a masked-only change keeps the status and the host line still, and a mask write stores exactly the masked data. They also check that `pin_drive` moves only on mask writes, that read data holds without a read strobe, and that an unmapped read returns zero. Other behaviours can only be shown by the bench's scenarios. These are the exact source latency through the synchronizer, the choice of the lowest source when several change together, and the precedence of an input event over a concurrent status write. The same holds for the XOR arithmetic of the level record across masked changes and the untouched contents of the general registers after writes to unmapped offsets.

// File: rtl/bih_pkg.sv
package bih_pkg;

  localparam int          BUS_DW   = 32;
  localparam int          BUS_AW   = 8;
  localparam int          SRC_N    = 16;
  localparam int          GP_COUNT = 10;
  localparam logic [31:0] KEEP_MSK = 32'h000F_EEFF;

  localparam logic [7:0]  OFS_ENABLE = 8'hC0;
  localparam logic [7:0]  OFS_STATUS = 8'hD0;

  // byte offset of each general storage register
  function automatic logic [7:0] gp_offset(input int idx);
    case (idx)
      0:       return 8'h10;
      1:       return 8'h14;
      2:       return 8'h40;
      3:       return 8'h60;
      4:       return 8'h80;
      5:       return 8'h84;
      6:       return 8'h88;
      7:       return 8'h90;
      8:       return 8'hE0;
      default: return 8'hE4;
    endcase
  endfunction

endpackage

// File: rtl/bih_sync.sv
module bih_sync #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] chg_o
);

  logic [N-1:0] s1_q, s2_q, lvl_q, chg_q;
  logic [N-1:0] s1_d, s2_d, lvl_d, chg_d;

  always_comb begin
    s1_d  = async_i;
    s2_d  = s1_q;
    lvl_d = s2_q;
    chg_d = s2_q ^ lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      lvl_q <= '0;
      chg_q <= '0;
    end else begin
      s1_q  <= s1_d;
      s2_q  <= s2_d;
      lvl_q <= lvl_d;
      chg_q <= chg_d;
    end
  end

  assign lvl_o = lvl_q;
  assign chg_o = chg_q;

  // R4
  chg_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_o == (lvl_o ^ $past(lvl_o))));

endmodule

// File: rtl/bih_core.sv
module bih_core #(
  parameter int          N    = 16,
  parameter int          DW   = 32,
  parameter logic [31:0] MASK = 32'h000F_EEFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  chg_i,
  input  logic [N-1:0]  lvl_i,
  input  logic          en_wr,
  input  logic          st_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] en_o,
  output logic [DW-1:0] st_o,
  output logic          irq_o,
  output logic [N-1:0]  pin_o
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [DW-1:0] KEEP = DW'(MASK);

  logic [DW-1:0] en_q, en_d, st_q, st_d;
  logic [N-1:0]  prev_q, prev_d, pin_q, pin_d;
  logic [N-1:0]  ena, mix, base;
  logic          irq_q, irq_d, hit;
  logic [IW-1:0] win;

  always_comb begin
    ena = chg_i & en_q[N-1:0];
    hit = |ena;
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ena[i]) win = IW'(i);
    end
  end

  always_comb begin
    mix    = prev_q ^ st_q[N-1:0];
    base   = en_wr ? mix : prev_q;
    prev_d = (base & ~chg_i) | (lvl_i & chg_i);
    pin_d  = en_wr ? mix : pin_q;
    en_d   = en_wr ? (wdata & KEEP) : en_q;
    if (hit)        st_d = DW'(1) << win;
    else if (st_wr) st_d = wdata & KEEP;
    else            st_d = st_q;
    irq_d  = hit ? lvl_i[win] : irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      st_q   <= '0;
      prev_q <= '0;
      pin_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      st_q   <= st_d;
      prev_q <= prev_d;
      pin_q  <= pin_d;
      irq_q  <= irq_d;
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign irq_o = irq_q;
  assign pin_o = pin_q;

  // R4
  onehot_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chg_i & en_o[N-1:0])) |=> ($countones(st_o) == 1));

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chg_i) && !(|(chg_i & en_o[N-1:0])) && !st_wr) |=> ($stable(st_o) && $stable(irq_o)));

  // R3
  enable_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_o == ($past(wdata) & KEEP)));

  // R8
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(pin_o));

endmodule

// File: rtl/bih_regs.sv
module bih_regs
  import bih_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 8,
  parameter int NGP = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] en_i,
  input  logic [DW-1:0] st_i,
  output logic          en_wr,
  output logic          st_wr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] gp_q [NGP];
  logic [DW-1:0] rd_val, rdata_q, rdata_d;
  logic          rd_hit;

  assign en_wr = wr_en && (addr == AW'(OFS_ENABLE));
  assign st_wr = wr_en && (addr == AW'(OFS_STATUS));

  for (genvar g = 0; g < NGP; g++) begin : g_store
    logic          we;
    logic [DW-1:0] nxt;
    assign we  = wr_en && (addr == AW'(gp_offset(g)));
    assign nxt = we ? wdata : gp_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gp_q[g] <= '0;
      else        gp_q[g] <= nxt;
    end
  end

  always_comb begin
    rd_val = '0;
    rd_hit = 1'b0;
    if (addr == AW'(OFS_ENABLE)) begin
      rd_val = en_i;
      rd_hit = 1'b1;
    end
    if (addr == AW'(OFS_STATUS)) begin
      rd_val = st_i;
      rd_hit = 1'b1;
    end
    for (int g = 0; g < NGP; g++) begin
      if (addr == AW'(gp_offset(g))) begin
        rd_val = gp_q[g];
        rd_hit = 1'b1;
      end
    end
    rdata_d = rd_en ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/board_irq_hub.sv
module board_irq_hub
  import bih_pkg::*;
#(
  parameter int          DW   = BUS_DW,
  parameter int          AW   = BUS_AW,
  parameter int          N    = SRC_N,
  parameter int          NGP  = GP_COUNT,
  parameter logic [31:0] MASK = KEEP_MSK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  irq_src,
  output logic          irq_host,
  output logic [N-1:0]  pin_drive
);

  logic [N-1:0]  lvl, chg;
  logic [DW-1:0] en_val, st_val;
  logic          en_wr, st_wr;

  bih_sync #(.N(N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (irq_src),
    .lvl_o   (lvl),
    .chg_o   (chg)
  );

  bih_core #(.N(N), .DW(DW), .MASK(MASK)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .chg_i (chg),
    .lvl_i (lvl),
    .en_wr (en_wr),
    .st_wr (st_wr),
    .wdata (bus_wdata),
    .en_o  (en_val),
    .st_o  (st_val),
    .irq_o (irq_host),
    .pin_o (pin_drive)
  );

  bih_regs #(.DW(DW), .AW(AW), .NGP(NGP)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .wr_en (bus_wr),
    .rd_en (bus_rd),
    .en_i  (en_val),
    .st_i  (st_val),
    .en_wr (en_wr),
    .st_wr (st_wr),
    .rdata (bus_rdata)
  );

endmodule

// File: tb/board_irq_hub_test.sv
`timescale 1ns/1ps
module board_irq_hub_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_src = '0;
  logic        irq_host;
  logic [15:0] pin_drive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  board_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_host(irq_host), .pin_drive(pin_drive)
  );

  function automatic logic [7:0] gp_ofs(input int i);
    logic [7:0] t [10] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80,
                           8'h84, 8'h88, 8'h90, 8'hE0, 8'hE4};
    return t[i];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // drive sources at a falling edge, return after the fourth rising edge
  task automatic src(input logic [15:0] v);
    @(negedge clk);
    irq_src = v;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: compares read data against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10: actual=%h expected=none queued", bus_rdata);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    check("R1 irq_host", {31'd0, irq_host}, 32'd0);
    check("R1 pin_drive", {16'd0, pin_drive}, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    rd(8'hC0, 32'd0, "R1 enable");
    rd(8'hD0, 32'd0, "R1 status");
    rd(8'h10, 32'd0, "R1 gp");

    // R2 general storage
    for (int i = 0; i < 10; i++) wr(gp_ofs(i), 32'hA500_0000 + i * 32'h0101_0101 + 32'h5A);
    for (int i = 0; i < 10; i++) rd(gp_ofs(i), 32'hA500_0000 + i * 32'h0101_0101 + 32'h5A, "R2");

    // R3 writable mask
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'hC0, 32'h000F_EEFF, "R3 enable");
    wr(8'hD0, 32'hFFFF_FFFF);
    rd(8'hD0, 32'h000F_EEFF, "R3 status");
    wr(8'hD0, 32'hFFF0_1100);
    rd(8'hD0, 32'h0000_0000, "R3 status masked bits");
    wr(8'hC0, 32'h0000_00FF);
    drain();

    // R4 enabled change
    src(16'h0008);
    check("R4 irq rise", {31'd0, irq_host}, 32'd1);
    rd(8'hD0, 32'h0000_0008, "R4 status");
    src(16'h0000);
    check("R4 irq fall", {31'd0, irq_host}, 32'd0);
    src(16'h0008);
    check("R4 irq rise again", {31'd0, irq_host}, 32'd1);

    // R5 disabled source 13
    src(16'h2008);
    check("R5 irq held", {31'd0, irq_host}, 32'd1);
    rd(8'hD0, 32'h0000_0008, "R5 status held");

    // R6 sources 2 and 5 rise together
    src(16'h202C);
    check("R6 irq", {31'd0, irq_host}, 32'd1);
    rd(8'hD0, 32'h0000_0004, "R6 lowest wins");
    // source 2 falls while source 7 rises
    src(16'h20A8);
    check("R6 irq low level", {31'd0, irq_host}, 32'd0);
    rd(8'hD0, 32'h0000_0004, "R6 lowest wins fall");
    drain();

    // R7 input event beats a concurrent status write
    @(negedge clk);
    irq_src = 16'h20AA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    bus_addr = 8'hD0; bus_wdata = 32'h0000_0010; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R7 irq", {31'd0, irq_host}, 32'd1);
    rd(8'hD0, 32'h0000_0002, "R7 status");
    wr(8'hD0, 32'h0000_0030);
    rd(8'hD0, 32'h0000_0030, "R7 plain status write");
    drain();

    // R8 levels 0x20AA, status 0x30
    check("R8 pin before", {16'd0, pin_drive}, 32'd0);
    wr(8'hC0, 32'h0000_00FF);
    check("R8 pin first", {16'd0, pin_drive}, 32'h0000_209A);
    wr(8'hC0, 32'h0000_00FF);
    check("R8 pin second", {16'd0, pin_drive}, 32'h0000_20AA);
    wr(8'h10, 32'h1234_5678);
    check("R8 pin stable", {16'd0, pin_drive}, 32'h0000_20AA);

    // R9 unmapped
    wr(8'h24, 32'hDEAD_BEEF);
    wr(8'hFC, 32'hDEAD_BEEF);
    rd(8'h24, 32'd0, "R9 unmapped 0x24");
    rd(8'hFC, 32'd0, "R9 unmapped 0xFC");
    rd(8'h14, 32'hA500_0000 + 32'h0101_0101 + 32'h5A, "R9 gp intact");
    rd(8'hE4, 32'hA500_0000 + 9 * 32'h0101_0101 + 32'h5A, "R9 gp intact");
    rd(8'hC0, 32'h0000_00FF, "R9 enable intact");

    // R10 hold without read strobe
    rd(8'h10, 32'h1234_5678, "R10 read");
    drain();
    wr(8'h10, 32'h0BAD_F00D);
    @(negedge clk);
    check("R10 hold", bus_rdata, 32'h1234_5678);
    rd(8'h10, 32'h0BAD_F00D, "R10 new read");
    drain();

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule